// File: doc/BRIEF.md
# Serial ADC Result Frame Receiver

This block takes in the result frames of a delta-sigma converter that drives its own serial clock. Both the clock line and the data line are brought into the system clock domain through a synchronizer. The block then follows the converter's handshake. While a conversion runs, both lines sit high. When both lines fall low, the conversion has finished and a frame follows. The frame is shifted in on the rising edges of the serial clock. Each frame holds a three-bit status header (end-of-conversion flag, a bit that must be zero, and the sign) followed by `DATA_W` result bits, most significant first.

A well-formed frame produces a registered magnitude and sign together with a one-cycle `res_valid_o` pulse. A frame that is malformed or cut short produces a one-cycle `frame_err_o` pulse and leaves the result registers unchanged. The result stream has no back-pressure. The converter cannot be stalled, so there is no ready input. A consumer must take the result in the cycle `res_valid_o` is high, or read the held registers before the next pulse. The system clock must run at least four times faster than the serial clock. The chip-select output is held low so that the converter runs continuously.

Top module: `adc_frame_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge, `res_valid_o` and `frame_err_o` go low, `res_data_o` goes to 0 and `res_sign_o` goes to 0. Any partly received frame is discarded, and the next frame is accepted only after both lines have been high and then both low again.
- R2: `cs_n_o` is low at all times.
- R3: A frame starts only after both lines have been seen high together and then both low together. Serial clock edges that arrive outside this sequence produce neither pulse.
- R4: Inside a frame, the data line is sampled on each rising edge of the serial clock. The first sample is the end-of-conversion bit, the second is the zero bit, the third is the sign, and the remaining `DATA_W` samples are the magnitude, MSB first. A frame holds exactly `DATA_W`+3 rising edges.
- R5: For a frame whose end-of-conversion bit and zero bit are both 0, `res_data_o` and `res_sign_o` take the received values and `res_valid_o` is high for exactly one cycle. This happens within 5 system cycles after the final rising edge reaches `sck_i`.
- R6: If the end-of-conversion bit or the zero bit of a complete frame is 1, `frame_err_o` pulses for one cycle, `res_valid_o` stays low and the result outputs keep their values.
- R7: If, inside a frame, the data line rises while the serial clock is high, the frame is abandoned before its final edge. `frame_err_o` pulses once, no valid pulse follows, and the block waits for the next end of conversion.
- R8: `res_data_o` and `res_sign_o` change only in a cycle in which `res_valid_o` is high.
- R9: `res_valid_o` and `frame_err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck_i | input | 1 | Serial clock driven by the converter |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip select to the converter, held low |
| res_valid_o | output | 1 | One-cycle pulse: a new result is present |
| res_data_o | output | DATA_W | Result magnitude, held between pulses |
| res_sign_o | output | 1 | Result sign, held between pulses |
| frame_err_o | output | 1 | One-cycle pulse: malformed or truncated frame |

## Verification
The bench builds the receiver with `DATA_W` = 6 and `SYNC_STAGES` = 2. This makes a frame nine bits long, so every magnitude under both signs, 128 frames in all, can be sent and compared against the value the bench packs itself. With such short frames there is also room for frames with a bad header bit, a truncated frame, clock pulses with no end-of-conversion handshake, and a reset in the middle of a frame. After each of these, the bench confirms that the held result is unchanged.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;
  // Status bits preceding the result: end-of-conversion, fixed zero, sign
  localparam int HDR_W = 3;

  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,  // waiting for both lines high (conversion running)
    ST_EOC   = 2'd1,  // waiting for both lines low (conversion finished)
    ST_SHIFT = 2'd2   // counting rising edges, shifting bits in
  } rx_state_e;
endpackage

// File: rtl/adc_rx_sync.sv
module adc_rx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  genvar g;
  for (g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
    end
    assign lvl_o[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_o;
  end

  assign rise_o = lvl_o & ~lvl_q;

  initial begin
    AST_SYNC_DEPTH : assert (STAGES >= 2); // R3
  end
endmodule

// File: rtl/adc_rx_seq.sv
module adc_rx_seq
  import adc_rx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sck_lvl_i,
  input  logic                      sdo_lvl_i,
  input  logic                      sck_rise_i,
  input  logic                      sdo_rise_i,
  output logic [HDR_W+DATA_W-1:0]   frame_bits_o,
  output logic                      frame_done_o,
  output logic                      frame_abort_o
);
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  rx_state_e          state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] shreg_q;
  logic               done_q;
  logic               abort_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_CONV;
      cnt_q   <= '0;
      shreg_q <= '0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      case (state_q)
        ST_CONV: begin
          if (sck_lvl_i && sdo_lvl_i) state_q <= ST_EOC;
        end
        ST_EOC: begin
          if (!sck_lvl_i && !sdo_lvl_i) begin
            state_q <= ST_SHIFT;
            cnt_q   <= '0;
          end
        end
        ST_SHIFT: begin
          if (sck_rise_i) begin
            shreg_q <= {shreg_q[FRAME_W-2:0], sdo_lvl_i};
            if (cnt_q == LAST_BIT) begin
              done_q  <= 1'b1;
              cnt_q   <= '0;
              state_q <= ST_CONV;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end else if (sdo_rise_i && sck_lvl_i) begin
            // data line rose with clock high: a new conversion began early
            abort_q <= 1'b1;
            state_q <= ST_EOC;
          end
        end
        default: state_q <= ST_CONV;
      endcase
    end
  end

  assign frame_bits_o  = shreg_q;
  assign frame_done_o  = done_q;
  assign frame_abort_o = abort_q;

  AST_CNT_BOUND : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_BIT); // R4
  AST_CNT_ON_EDGE : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT && !sck_rise_i) |=> $stable(cnt_q)); // R4
  AST_DONE_ABORT_EXCL : assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && abort_q)); // R9
  AST_START_HANDSHAKE : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV) |=> (state_q != ST_SHIFT)); // R3
endmodule

// File: rtl/adc_rx_out.sv
module adc_rx_out
  import adc_rx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [HDR_W+DATA_W-1:0] frame_bits_i,
  input  logic                    frame_done_i,
  input  logic                    frame_abort_i,
  output logic                    res_valid_o,
  output logic [DATA_W-1:0]       res_data_o,
  output logic                    res_sign_o,
  output logic                    frame_err_o
);
  localparam int FRAME_W = HDR_W + DATA_W;

  logic eoc_bit, zero_bit, sign_bit, hdr_ok;

  assign eoc_bit  = frame_bits_i[FRAME_W-1];
  assign zero_bit = frame_bits_i[FRAME_W-2];
  assign sign_bit = frame_bits_i[DATA_W];
  assign hdr_ok   = !eoc_bit && !zero_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
      res_sign_o  <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      res_valid_o <= frame_done_i && hdr_ok;
      frame_err_o <= frame_abort_i || (frame_done_i && !hdr_ok);
      if (frame_done_i && hdr_ok) begin
        res_data_o <= frame_bits_i[DATA_W-1:0];
        res_sign_o <= sign_bit;
      end
    end
  end

  AST_VALID_PULSE : assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o); // R5
  AST_ERR_PULSE : assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |=> !frame_err_o); // R6
  AST_NO_BOTH : assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid_o && frame_err_o)); // R9
  AST_RESULT_HOLD : assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_o |-> ($stable(res_data_o) && $stable(res_sign_o))); // R8
endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx
  import adc_rx_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              sdo_i,
  output logic              cs_n_o,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic              res_sign_o,
  output logic              frame_err_o
);
  localparam int FRAME_W = HDR_W + DATA_W;

  logic [1:0]         line_lvl, line_rise;
  logic [FRAME_W-1:0] frame_bits;
  logic               frame_done, frame_abort;

  assign cs_n_o = 1'b0;

  adc_rx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sdo_i, sck_i}),
    .lvl_o   (line_lvl),
    .rise_o  (line_rise)
  );

  adc_rx_seq #(.DATA_W(DATA_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .sck_lvl_i     (line_lvl[0]),
    .sdo_lvl_i     (line_lvl[1]),
    .sck_rise_i    (line_rise[0]),
    .sdo_rise_i    (line_rise[1]),
    .frame_bits_o  (frame_bits),
    .frame_done_o  (frame_done),
    .frame_abort_o (frame_abort)
  );

  adc_rx_out #(.DATA_W(DATA_W)) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_bits_i  (frame_bits),
    .frame_done_i  (frame_done),
    .frame_abort_i (frame_abort),
    .res_valid_o   (res_valid_o),
    .res_data_o    (res_data_o),
    .res_sign_o    (res_sign_o),
    .frame_err_o   (frame_err_o)
  );
endmodule

// File: tb/adc_frame_rx_tb.sv
`timescale 1ns/1ps
module adc_frame_rx_tb;
  localparam int DW   = 6;
  localparam int FW   = DW + 3;
  localparam int HALF = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sck = 1'b0;
  logic          sdo = 1'b0;
  logic          cs_n, valid, sign, ferr;
  logic [DW-1:0] data;

  int n_checks = 0;
  int n_fail   = 0;
  int vcnt = 0, ecnt = 0, overlap = 0, wide = 0;
  logic          prev_v = 1'b0, prev_e = 1'b0;
  logic [DW-1:0] cap_d = '0;
  logic          cap_s = 1'b0;

  always #2.5 clk = ~clk;

  adc_frame_rx #(.DATA_W(DW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdo_i(sdo), .cs_n_o(cs_n),
    .res_valid_o(valid), .res_data_o(data), .res_sign_o(sign),
    .frame_err_o(ferr)
  );

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin vcnt++; cap_d = data; cap_s = sign; end
      if (ferr) ecnt++;
      if (valid && ferr) overlap++;
      if ((valid && prev_v) || (ferr && prev_e)) wide++;
      prev_v = valid;
      prev_e = ferr;
    end else begin
      prev_v = 1'b0;
      prev_e = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // conversion, end-of-conversion handshake, then nbits rising edges
  task automatic send_bits(input logic [FW-1:0] word, input int nbits);
    sck = 1'b1; sdo = 1'b1; cyc(10);
    sck = 1'b0; sdo = 1'b0; cyc(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdo = word[FW-1-i]; cyc(HALF);
      sck = 1'b1; cyc(HALF);
      if (i != nbits - 1) sck = 1'b0;
    end
    sdo = 1'b1; cyc(10);
  endtask

  function automatic logic [FW-1:0] pack(input bit eoc, input bit zb, input bit s, input int d);
    return {eoc, zb, s, DW'(d)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v0, e0;
    logic [DW-1:0] held_d;
    logic          held_s;
    cyc(5);
    // R1: reset state
    check(valid == 0 && ferr == 0, "R1 pulses low in reset", int'(valid) + int'(ferr), 0);
    check(data == 0 && sign == 0, "R1 result cleared in reset", int'(data), 0);
    check(cs_n == 0, "R2 chip select low", int'(cs_n), 0);
    rst_n = 1'b1; cyc(4);

    // R3: clock pulses without the high-then-low handshake
    for (int i = 0; i < FW + 2; i++) begin
      sck = 1'b1; cyc(HALF); sck = 1'b0; cyc(HALF);
    end
    cyc(8);
    check(vcnt == 0 && ecnt == 0, "R3 no pulse without handshake", vcnt + ecnt, 0);

    // R4/R5: every magnitude under both signs
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < (1 << DW); d++) begin
        v0 = vcnt; e0 = ecnt;
        send_bits(pack(1'b0, 1'b0, s[0], d), FW);
        check(vcnt == v0 + 1 && ecnt == e0, "R5 one valid pulse", vcnt - v0, 1);
        check(cap_d == DW'(d) && cap_s == s[0], "R4 captured magnitude", int'(cap_d), d);
      end
    end
    check(cs_n == 0, "R2 chip select low after traffic", int'(cs_n), 0);

    // R6: bad header bits
    held_d = data; held_s = sign;
    for (int k = 1; k < 4; k++) begin
      v0 = vcnt; e0 = ecnt;
      send_bits(pack(k[0], k[1], 1'b1, 21 + k), FW);
      check(ecnt == e0 + 1 && vcnt == v0, "R6 header error pulse", ecnt - e0, 1);
      check(data == held_d && sign == held_s, "R6 result unchanged", int'(data), int'(held_d));
    end

    // R7: frame cut short, data rises with clock high
    v0 = vcnt; e0 = ecnt;
    send_bits(pack(1'b0, 1'b0, 1'b1, 0), 5);
    check(ecnt == e0 + 1 && vcnt == v0, "R7 truncated frame error", ecnt - e0, 1);
    check(data == held_d, "R8 result held after truncation", int'(data), int'(held_d));
    v0 = vcnt;
    send_bits(pack(1'b0, 1'b0, 1'b0, 45), FW);
    check(vcnt == v0 + 1 && data == DW'(45) && sign == 0, "R7 recovery frame", int'(data), 45);

    // R8: result held while idle
    cyc(50);
    check(data == DW'(45) && sign == 0, "R8 idle hold", int'(data), 45);

    // R1: reset in the middle of a frame
    v0 = vcnt; e0 = ecnt;
    sck = 1'b1; sdo = 1'b1; cyc(10);
    sck = 1'b0; sdo = 1'b0; cyc(HALF);
    for (int i = 0; i < 4; i++) begin
      sdo = 1'b0; cyc(HALF); sck = 1'b1; cyc(HALF); sck = 1'b0;
    end
    rst_n = 1'b0; cyc(3);
    check(data == 0 && valid == 0 && ferr == 0, "R1 mid-frame reset clears", int'(data), 0);
    sck = 1'b1; sdo = 1'b1; cyc(2);
    rst_n = 1'b1; cyc(20);
    check(vcnt == v0 && ecnt == e0, "R1 partial frame discarded", vcnt - v0, 0);
    send_bits(pack(1'b0, 1'b0, 1'b1, 7), FW);
    check(vcnt == v0 + 1 && data == DW'(7) && sign == 1, "R5 frame after reset", int'(data), 7);

    cyc(8);
    check(overlap == 0, "R9 valid and error never together", overlap, 0);
    check(wide == 0, "R5 pulses one cycle wide", wide, 0);
    finish_run();
  end
endmodule